// File: doc/BRIEF.md
# Link Control and Status Register with CRC Error Escalation

This block holds the 16-bit control and status word of one serial point-to-point link, plus a read-only link-width word. Software reaches both through a plain register port: `reg_sel` picks the word (0 = control, 1 = width), `reg_wr_en` writes `reg_wdata` into the control word, and `reg_rdata` always returns the selected word combinationally. No data stream crosses the block, so there is no valid/ready handshake. A write is taken on every clock edge where `reg_wr_en` is high, and it is never stalled.

The link layer reports initialization success (`link_init_ok`), CRC errors (`crc_err`) and the end of a CRC test (`crc_test_done`). The block drives three outputs toward the transmitter: bad-CRC forcing, a one-cycle CRC test start pulse, and a sync-flood request. It also drives the effective link-fail level, which holds off link initialization. A cold reset (`rst_n` low, asynchronous) clears everything. A warm reset (`warm_rst`, a synchronous one-cycle pulse) clears the volatile bits, but the link-fail flag survives it. The software copy of that flag becomes the effective value at the warm reset. When fatal escalation is enabled, a CRC error raises the sync-flood request and latches the link failure at once.

Control word layout: bit 5 init-done, bit 4 link-fail, bit 3 force-bad-CRC, bit 2 CRC-test-start/busy, bit 1 fatal-CRC enable. All other bits are reserved.

Top module: `lnk_ctl_regs`

## Requirements
- R1: While `rst_n` is low, every output is 0, both words read 0x0000, and link-fail (both the register bit and the `link_fail` output) is cleared.
- R2: Reserved control bits (15:6 and 0) always read 0. The width word reads 0x0000, which is the 8-bit code 000b in its out (14:12), in (10:8) and max-out (6:4) fields. A write with `reg_sel`=1 changes no state.
- R3: Bit 5 (init-done) becomes 1 the cycle after `link_init_ok` is high while `link_fail` is 0. It then holds, and it ignores writes. A warm reset clears it.
- R4: A control write copies `reg_wdata[4]` into bit 4 on the next cycle. A software write never changes the `link_fail` output.
- R5: On `warm_rst`, `link_fail` takes the value bit 4 held before the pulse, and bit 4 keeps its value.
- R6: Bit 3 is written by software and drives `crc_force_bad` directly. A warm reset clears it.
- R7: Writing 1 to bit 2 while it reads 0 sets it and pulses `crc_test_start` high for exactly the next cycle. Writing 0, or writing 1 while the bit is already 1, produces no pulse.
- R8: Bit 2 reads 0 from the cycle after a `crc_test_done` pulse, unless a new start is taken in that same cycle.
- R9: Bit 1 enables fatal escalation. When `crc_err` is high while bit 1 is set, the next cycle shows `sync_flood`=1, `link_fail`=1 and bit 4=1. This hardware set wins over a software clear of bit 4 in the same cycle.
- R10: `sync_flood` stays high until a warm or cold reset. A warm reset clears bits 3, 2 and 1 and `sync_flood`, and it takes priority over a control write and over a CRC error in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset, synchronous one-cycle pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Word select: 0 control, 1 width |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| link_init_ok | input | 1 | Low-level link initialization completed |
| crc_err | input | 1 | CRC error detected, one pulse per error |
| crc_test_done | input | 1 | CRC test sequence finished, pulse |
| crc_force_bad | output | 1 | Transmitter emits bad CRC on all traffic |
| crc_test_start | output | 1 | One-cycle start pulse to the CRC test engine |
| sync_flood | output | 1 | Request sync flooding on all links |
| link_fail | output | 1 | Effective link failure; holds off initialization |

## Verification
Random traffic mixes control writes, width-word writes, CRC errors, test-done pulses, initialization reports and rare warm resets. A bench reference model predicts every port each cycle. Cycles where CRC errors arrive with escalation enabled or disabled show whether the enable gates the flood. Warm resets that land after software changed bit 4 separate the pending copy from the effective value. Directed cases cover a start request while a test is busy, a CRC error together with a software clear of bit 4, a warm reset together with a write, and a mid-run cold reset.

// File: rtl/lnk_ctl_pkg.sv
package lnk_ctl_pkg;
  localparam int REG_W = 16;

  // bit positions decoded by software
  localparam int B_INIT  = 5;
  localparam int B_FAIL  = 4;
  localparam int B_FORCE = 3;
  localparam int B_TEST  = 2;
  localparam int B_FATAL = 1;

  // width field positions (low bit of each 3-bit field)
  localparam int F_OUT_LO  = 12;
  localparam int F_IN_LO   = 8;
  localparam int F_MAX_LO  = 4;

  typedef enum logic [2:0] {
    LW_8  = 3'b000,
    LW_16 = 3'b001,
    LW_32 = 3'b011
  } lnk_width_e;

  typedef struct packed {
    logic init_done;
    logic fail_pend;
    logic force_crc;
    logic test_busy;
    logic fatal_en;
  } ctl_state_t;

  function automatic logic [REG_W-1:0] width_word(lnk_width_e w);
    logic [REG_W-1:0] v;
    v = '0;
    v[F_OUT_LO +: 3] = w;
    v[F_IN_LO  +: 3] = w;
    v[F_MAX_LO +: 3] = w;
    return v;
  endfunction
endpackage

// File: rtl/lnk_ctl_fail.sv
module lnk_ctl_fail (
  input  logic clk,
  input  logic rst_n,
  input  logic warm_rst,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic crc_err,
  input  logic fatal_en,
  output logic fail_pend,
  output logic link_fail,
  output logic sync_flood
);
  logic fatal_hit;
  assign fatal_hit = crc_err & fatal_en;

  // pending copy: software-visible, survives warm reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fail_pend <= 1'b0;
    else if (warm_rst)   fail_pend <= fail_pend;
    else if (fatal_hit)  fail_pend <= 1'b1;
    else if (sw_wr)      fail_pend <= sw_val;
  end

  // effective level: loaded from pending on warm reset, set by hardware
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          link_fail <= 1'b0;
    else if (warm_rst)   link_fail <= fail_pend;
    else if (fatal_hit)  link_fail <= 1'b1;
  end

  // sync flood request, sticky until a reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sync_flood <= 1'b0;
    else if (warm_rst)   sync_flood <= 1'b0;
    else if (fatal_hit)  sync_flood <= 1'b1;
  end
endmodule

// File: rtl/lnk_ctl_crc.sv
module lnk_ctl_crc (
  input  logic clk,
  input  logic rst_n,
  input  logic warm_rst,
  input  logic sw_wr,
  input  logic wr_force,
  input  logic wr_start,
  input  logic wr_fatal,
  input  logic test_done,
  output logic force_crc,
  output logic test_busy,
  output logic test_start,
  output logic fatal_en
);
  logic fire;
  assign fire = sw_wr & wr_start & ~test_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_crc  <= 1'b0;
      fatal_en   <= 1'b0;
    end else if (warm_rst) begin
      force_crc  <= 1'b0;
      fatal_en   <= 1'b0;
    end else if (sw_wr) begin
      force_crc  <= wr_force;
      fatal_en   <= wr_fatal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_busy  <= 1'b0;
      test_start <= 1'b0;
    end else if (warm_rst) begin
      test_busy  <= 1'b0;
      test_start <= 1'b0;
    end else begin
      test_start <= fire;
      if (fire)           test_busy <= 1'b1;
      else if (test_done) test_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/lnk_ctl_init.sv
module lnk_ctl_init (
  input  logic clk,
  input  logic rst_n,
  input  logic warm_rst,
  input  logic init_ok,
  input  logic link_fail,
  output logic init_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       init_done <= 1'b0;
    else if (warm_rst)                init_done <= 1'b0;
    else if (init_ok && !link_fail)   init_done <= 1'b1;
  end
endmodule

// File: rtl/lnk_ctl_rdmux.sv
module lnk_ctl_rdmux
  import lnk_ctl_pkg::*;
#(
  parameter lnk_width_e WIDTH_CODE = LW_8
) (
  input  logic             reg_sel,
  input  ctl_state_t       st,
  output logic [REG_W-1:0] rdata
);
  localparam logic [REG_W-1:0] WIDTH_WORD = width_word(WIDTH_CODE);
  logic [REG_W-1:0] ctl_word;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i == B_INIT)       begin : g_i assign ctl_word[i] = st.init_done; end
    else if (i == B_FAIL)  begin : g_f assign ctl_word[i] = st.fail_pend; end
    else if (i == B_FORCE) begin : g_c assign ctl_word[i] = st.force_crc; end
    else if (i == B_TEST)  begin : g_t assign ctl_word[i] = st.test_busy; end
    else if (i == B_FATAL) begin : g_e assign ctl_word[i] = st.fatal_en;  end
    else                   begin : g_r assign ctl_word[i] = 1'b0;         end
  end

  assign rdata = reg_sel ? WIDTH_WORD : ctl_word;
endmodule

// File: rtl/lnk_ctl_regs.sv
module lnk_ctl_regs
  import lnk_ctl_pkg::*;
#(
  parameter lnk_width_e WIDTH_CODE = LW_8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             reg_wr_en,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             link_init_ok,
  input  logic             crc_err,
  input  logic             crc_test_done,
  output logic             crc_force_bad,
  output logic             crc_test_start,
  output logic             sync_flood,
  output logic             link_fail
);
  logic       ctl_wr;
  logic       fail_pend;
  logic       test_busy;
  logic       fatal_en;
  logic       init_done;
  ctl_state_t st;

  assign ctl_wr = reg_wr_en & ~reg_sel;

  lnk_ctl_fail u_fail (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst   (warm_rst),
    .sw_wr      (ctl_wr),
    .sw_val     (reg_wdata[B_FAIL]),
    .crc_err    (crc_err),
    .fatal_en   (fatal_en),
    .fail_pend  (fail_pend),
    .link_fail  (link_fail),
    .sync_flood (sync_flood)
  );

  lnk_ctl_crc u_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst   (warm_rst),
    .sw_wr      (ctl_wr),
    .wr_force   (reg_wdata[B_FORCE]),
    .wr_start   (reg_wdata[B_TEST]),
    .wr_fatal   (reg_wdata[B_FATAL]),
    .test_done  (crc_test_done),
    .force_crc  (crc_force_bad),
    .test_busy  (test_busy),
    .test_start (crc_test_start),
    .fatal_en   (fatal_en)
  );

  lnk_ctl_init u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .init_ok   (link_init_ok),
    .link_fail (link_fail),
    .init_done (init_done)
  );

  assign st.init_done = init_done;
  assign st.fail_pend = fail_pend;
  assign st.force_crc = crc_force_bad;
  assign st.test_busy = test_busy;
  assign st.fatal_en  = fatal_en;

  lnk_ctl_rdmux #(.WIDTH_CODE(WIDTH_CODE)) u_rd (
    .reg_sel (reg_sel),
    .st      (st),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/lnk_ctl_chk.sv
module lnk_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        warm_rst,
  input logic        reg_sel,
  input logic [15:0] reg_rdata,
  input logic        crc_err,
  input logic        crc_test_done,
  input logic        crc_force_bad,
  input logic        crc_test_start,
  input logic        sync_flood,
  input logic        link_fail,
  input logic        fail_pend,
  input logic        test_busy,
  input logic        fatal_en,
  input logic        init_done
);
  AST_WIDTH_RO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata == 16'h0000); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[15:6] == 10'd0 && !reg_rdata[0])); // R2
  AST_INIT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail && !init_done |=> !init_done); // R3
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst && !(crc_err && fatal_en) |=> $stable(link_fail)); // R4
  AST_WARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> link_fail == $past(fail_pend) && $stable(fail_pend)); // R5
  AST_WARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> !crc_force_bad && !fatal_en && !test_busy && !sync_flood); // R10
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_test_start |=> !crc_test_start); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_test_start) |-> $rose(test_busy)); // R7
  AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    crc_test_done && test_busy |=> !test_busy); // R8
  AST_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && fatal_en && !warm_rst |=> sync_flood && link_fail && fail_pend); // R9
  AST_FLOOD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flood && !warm_rst |=> sync_flood); // R10
endmodule

bind lnk_ctl_regs lnk_ctl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .warm_rst       (warm_rst),
  .reg_sel        (reg_sel),
  .reg_rdata      (reg_rdata),
  .crc_err        (crc_err),
  .crc_test_done  (crc_test_done),
  .crc_force_bad  (crc_force_bad),
  .crc_test_start (crc_test_start),
  .sync_flood     (sync_flood),
  .link_fail      (link_fail),
  .fail_pend      (fail_pend),
  .test_busy      (test_busy),
  .fatal_en       (fatal_en),
  .init_done      (init_done)
);

// File: tb/sim_lnk_ctl_regs.sv
module sim_lnk_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        link_init_ok = 1'b0;
  logic        crc_err = 1'b0;
  logic        crc_test_done = 1'b0;
  logic        crc_force_bad, crc_test_start, sync_flood, link_fail;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  bit m_init, m_lf, m_lfe, m_force, m_test, m_fen, m_flood, m_pulse;

  always #2 clk = ~clk;

  lnk_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_wr_en(reg_wr_en),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_init_ok(link_init_ok), .crc_err(crc_err), .crc_test_done(crc_test_done),
    .crc_force_bad(crc_force_bad), .crc_test_start(crc_test_start),
    .sync_flood(sync_flood), .link_fail(link_fail)
  );

  function automatic logic [15:0] exp_rdata();
    if (reg_sel) return 16'h0000;
    return {10'd0, m_init, m_lf, m_force, m_test, m_fen, 1'b0};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_init, m_lf, m_lfe, m_force, m_test, m_fen, m_flood, m_pulse} = '0;
  endtask

  task automatic model_step();
    bit wr, fatal, fire;
    if (warm_rst) begin
      m_lfe = m_lf; m_force = 0; m_test = 0; m_fen = 0;
      m_flood = 0; m_pulse = 0; m_init = 0;
      return;
    end
    wr    = reg_wr_en && !reg_sel;
    fatal = crc_err && m_fen;
    fire  = wr && reg_wdata[2] && !m_test;
    m_init = m_init || (link_init_ok && !m_lfe);
    if (wr) m_lf = reg_wdata[4];
    if (fatal) begin m_lf = 1; m_lfe = 1; m_flood = 1; end
    if (wr) begin m_force = reg_wdata[3]; m_fen = reg_wdata[1]; end
    if (fire) m_test = 1; else if (crc_test_done) m_test = 0;
    m_pulse = fire;
  endtask

  task automatic compare_all();
    logic [15:0] e;
    e = exp_rdata();
    if (reg_sel) chk("R2", "width word", reg_rdata, e);
    else begin
      chk("R2", "reserved bits", {reg_rdata[15:6], 5'd0, reg_rdata[0]}, 16'h0000);
      chk("R3", "init-done bit", 16'(reg_rdata[5]), 16'(e[5]));
      chk("R4", "fail bit", 16'(reg_rdata[4]), 16'(e[4]));
      chk("R6", "force bit", 16'(reg_rdata[3]), 16'(e[3]));
      chk("R8", "test bit", 16'(reg_rdata[2]), 16'(e[2]));
      chk("R9", "fatal enable bit", 16'(reg_rdata[1]), 16'(e[1]));
    end
    chk("R6", "crc_force_bad", 16'(crc_force_bad), 16'(m_force));
    chk("R7", "crc_test_start", 16'(crc_test_start), 16'(m_pulse));
    chk("R5", "link_fail", 16'(link_fail), 16'(m_lfe));
    chk("R10", "sync_flood", 16'(sync_flood), 16'(m_flood));
  endtask

  // drive at negedge, clock, update model, compare at next negedge
  task automatic step(bit w, bit wr, bit sel, logic [15:0] d, bit ok, bit ce, bit td);
    warm_rst = w; reg_wr_en = wr; reg_sel = sel; reg_wdata = d;
    link_init_ok = ok; crc_err = ce; crc_test_done = td;
    @(posedge clk);
    model_step();
    @(negedge clk);
    warm_rst = 0; reg_wr_en = 0; crc_err = 0; crc_test_done = 0; link_init_ok = 0;
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 16'h0, 0, 0, 0);
  endtask

  task automatic cold_reset();
    rst_n = 0;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    reg_sel = 0;
    chk("R1", "ctl word in reset", reg_rdata, 16'h0000);
    chk("R1", "outputs in reset",
        16'({crc_force_bad, crc_test_start, sync_flood, link_fail}), 16'h0);
    reg_sel = 1;
    #0.1;
    chk("R1", "width word in reset", reg_rdata, 16'h0000);
    reg_sel = 0;
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h1A2B));
    @(negedge clk);
    cold_reset();
    idle();

    // R7: start pulse, repeat start while busy gives no pulse, R8 done clears
    step(0, 1, 0, 16'h0004, 0, 0, 0);
    chk("R7", "pulse after start write", 16'(crc_test_start), 16'h1);
    step(0, 1, 0, 16'h0004, 0, 0, 0);
    chk("R7", "no pulse while busy", 16'(crc_test_start), 16'h0);
    step(0, 0, 0, 16'h0, 0, 0, 1);
    chk("R8", "busy clears on done", 16'(reg_rdata[2]), 16'h0);

    // R9: fatal enable, CRC error together with a software clear of bit 4
    step(0, 1, 0, 16'h0002, 0, 0, 0);
    step(0, 1, 0, 16'h0002, 0, 1, 0);
    chk("R9", "hw set beats sw clear", 16'(reg_rdata[4]), 16'h1);
    chk("R9", "flood raised", 16'(sync_flood), 16'h1);
    // R4: software clear of bit 4 leaves the effective level alone
    step(0, 1, 0, 16'h0000, 0, 0, 0);
    chk("R4", "link_fail unaffected by sw", 16'(link_fail), 16'h1);
    // R3: init blocked while failed
    step(0, 0, 0, 16'h0, 1, 0, 0);
    chk("R3", "init blocked by fail", 16'(reg_rdata[5]), 16'h0);
    // R10/R5: warm reset together with a write
    step(1, 1, 0, 16'h001A, 0, 0, 0);
    chk("R5", "link_fail loads pending 0", 16'(link_fail), 16'h0);
    chk("R10", "warm beats write", 16'(reg_rdata[3:1]), 16'h0);
    step(0, 1, 0, 16'h0010, 0, 0, 0);
    step(1, 0, 0, 16'h0, 0, 0, 0);
    chk("R5", "link_fail loads pending 1", 16'(link_fail), 16'h1);
    chk("R5", "bit 4 kept over warm", 16'(reg_rdata[4]), 16'h1);
    // R2: write to width word ignored
    step(0, 1, 1, 16'hFFFF, 0, 0, 0);
    chk("R2", "width word write ignored", reg_rdata, 16'h0000);
    cold_reset();

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      d = 16'($urandom());
      step(($urandom() % 40) == 0, ($urandom() % 3) == 0, ($urandom() % 4) == 0, d,
           ($urandom() % 4) == 0, ($urandom() % 8) == 0, ($urandom() % 6) == 0);
      if (i == 2000) cold_reset();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule